// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block handles interrupts for a small 8-bit processor core with a 16-bit program counter. It holds one pending flag per request source and picks a source only when the core reports that an instruction has finished. When it picks a source, it does four things in order:

- it clears the global enable;
- it writes the return address to the stack as two bytes;
- it holds the core's fetch stage through a busy output;
- it loads the program counter with the address of that source's vector slot.

On a return-from-interrupt strobe, the block reads the two bytes back, reloads the program counter and sets the global enable again. Only the program counter is saved. Any status register must be saved and restored by the handler code.

The core supplies the address of the next instruction on `pc_next` together with the boundary strobe. The stack memory sits outside the block. It is addressed by `sp` and read combinationally through `stk_rdata`.

Top module: `irq_sequencer`

## Requirements
- R1: The block accepts a source only in the idle state, in a cycle where `insn_done` is high, the global enable is set, no return strobe is present and at least one pending flag for sources 1..NSRC-1 is set. In the cycle after acceptance, `busy` is high.
- R2: Accepting a source clears `gie` in the next cycle. `gie` stays clear until a return completes or `gie_set` is pulsed.
- R3: Entry writes the low byte of `pc_next` at `sp` and then the high byte at `sp`-1. `sp` decrements by one after each of the two writes.
- R4: `busy` stays high for exactly 4 cycles on entry. `pc_load` is high only in the fourth of those cycles, with `pc_value` equal to 4 times the source number (source n fetches from byte address 4*n, so source 10 gives 0x0028).
- R5: When several sources are pending at the same boundary, the lowest-numbered one is taken.
- R6: A request that arrives while `gie` is clear stays pending. It is accepted at the first boundary after `gie` is set.
- R7: A source's pending flag clears in the cycle its redirect is issued, so a single request enters its handler once.
- R8: A return strobe in the idle state starts a 3-cycle return:
  - `sp` increments;
  - the high byte is read at `sp` and `sp` increments again;
  - the low byte is read, `pc_load` is high with the restored address, and `gie` is set from the next cycle.
- R9: Request bit 0 (the reset slot) never causes an entry.
- R10: When a return strobe and an acceptable boundary occur in the same cycle, the return is performed first. The pending request is taken at a later boundary.
- R11: After reset, `gie` is 0, `busy` is 0 and `sp` equals SP_INIT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Request pulses, one bit per source; bit 0 is ignored |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| pc_next | input | 16 | Address of the next instruction, valid with `insn_done` |
| reti | input | 1 | Return-from-interrupt strobe |
| gie_set | input | 1 | Sets the global enable (software enable instruction) |
| gie | output | 1 | Global interrupt enable state |
| busy | output | 1 | Entry or return in progress; the core holds its fetch stage |
| sp | output | 16 | Stack pointer, also the stack memory address |
| stk_we | output | 1 | Stack byte write strobe |
| stk_wdata | output | 8 | Stack write byte |
| stk_re | output | 1 | Stack byte read strobe |
| stk_rdata | input | 8 | Stack read byte, combinational from `sp` |
| pc_load | output | 1 | Program counter load strobe |
| pc_value | output | 16 | Value loaded into the program counter |

## Verification
The embedded assertions check, on every cycle, the local rules:

- the stack pointer moves by one per write and per read;
- writes and reads never overlap;
- a vector load is slot-aligned and never targets slot 0;
- the global enable clears on entry and sets after a return.

Only the bench's reference model can show the properties that span several events:

- lowest-first arbitration among pending sources;
- a request held pending across a period with the enable cleared;
- a request entering its handler only once;
- byte order on the stack;
- nested entries returning in last-in-first-out order;
- a return winning over a simultaneous boundary.

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int          NSRC    = 16,
  parameter logic [15:0] SP_INIT = 16'h00FF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            insn_done,
  input  logic [15:0]     pc_next,
  input  logic            reti,
  input  logic            gie_set,
  output logic            gie,
  output logic            busy,
  output logic [15:0]     sp,
  output logic            stk_we,
  output logic [7:0]      stk_wdata,
  output logic            stk_re,
  input  logic [7:0]      stk_rdata,
  output logic            pc_load,
  output logic [15:0]     pc_value
);
  localparam int SW = (NSRC > 2) ? $clog2(NSRC) : 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PLO, ST_PHI, ST_WAIT, ST_JMP, ST_RINC, ST_RHI, ST_RLO
  } state_t;

  state_t          state;
  logic [NSRC-1:0] pend;
  logic [SW-1:0]   src_q;
  logic [15:0]     ret_q;
  logic [7:0]      hi_q;
  logic [SW-1:0]   pick;
  logic            any_pend;
  logic            accept;
  logic            ret_go;
  logic            ret_done;
  logic [NSRC-1:0] clr_mask;

  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 1; i--)
      if (pend[i]) pick = SW'(i);
  end

  assign any_pend = |(pend >> 1);
  assign ret_go   = (state == ST_IDLE) && reti;
  assign accept   = (state == ST_IDLE) && insn_done && gie && any_pend && !reti;
  assign ret_done = (state == ST_RLO);
  assign clr_mask = (state == ST_JMP) ? (NSRC'(1) << src_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pend  <= '0;
      src_q <= '0;
      ret_q <= '0;
      hi_q  <= '0;
      gie   <= 1'b0;
      sp    <= SP_INIT;
    end else begin
      pend <= ((pend & ~clr_mask) | irq_req) & ~NSRC'(1);
      if (accept)        gie <= 1'b0;
      else if (ret_done) gie <= 1'b1;
      else if (gie_set)  gie <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (ret_go) state <= ST_RINC;
          else if (accept) begin
            state <= ST_PLO;
            src_q <= pick;
            ret_q <= pc_next;
          end
        end
        ST_PLO:  begin sp <= sp - 16'd1; state <= ST_PHI;  end
        ST_PHI:  begin sp <= sp - 16'd1; state <= ST_WAIT; end
        ST_WAIT: state <= ST_JMP;
        ST_JMP:  state <= ST_IDLE;
        ST_RINC: begin sp <= sp + 16'd1; state <= ST_RHI; end
        ST_RHI:  begin sp <= sp + 16'd1; hi_q <= stk_rdata; state <= ST_RLO; end
        ST_RLO:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign stk_we    = (state == ST_PLO) || (state == ST_PHI);
  assign stk_wdata = (state == ST_PLO) ? ret_q[7:0] : (state == ST_PHI) ? ret_q[15:8] : 8'h00;
  assign stk_re    = (state == ST_RHI) || (state == ST_RLO);
  assign pc_load   = (state == ST_JMP) || (state == ST_RLO);
  assign pc_value  = (state == ST_JMP) ? (16'(src_q) << 2) :
                     (state == ST_RLO) ? {hi_q, stk_rdata} : 16'h0000;

  AST_ENTRY_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n) accept |=> (!gie && busy)); // R2
  AST_PUSH_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n) stk_we |=> (sp == $past(sp) - 16'd1)); // R3
  AST_POP_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RINC || state == ST_RHI) |=> (sp == $past(sp) + 16'd1)); // R8
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n) !(stk_we && stk_re)); // R3
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !pc_load); // R4
  AST_VECTOR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) (pc_load && state == ST_JMP) |-> (pc_value[1:0] == 2'b00 && pc_value != 16'h0000)); // R9
  AST_RETURN_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n) ret_done |=> gie); // R8
endmodule

// File: tb/irq_sequencer_bench.sv
module irq_sequencer_bench;
  localparam int          NSRC    = 16;
  localparam logic [15:0] SP_INIT = 16'h00FF;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic            insn_done = 1'b0;
  logic [15:0]     pc_next = '0;
  logic            reti = 1'b0;
  logic            gie_set = 1'b0;
  logic            gie, busy, stk_we, stk_re, pc_load;
  logic [15:0]     sp, pc_value;
  logic [7:0]      stk_wdata, stk_rdata;
  logic [7:0]      mem [256];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int          ph = 0;
  int          m_src = 0;
  logic [15:0] m_sp = SP_INIT;
  logic        m_gie = 1'b0;
  logic [NSRC-1:0] m_pend = '0;
  logic [15:0] m_ret = '0;
  logic [15:0] frames [$];
  logic [15:0] last_vec = '0;
  logic [15:0] last_ret = '0;
  int          entries = 0;

  always #5 clk = ~clk;

  assign stk_rdata = mem[sp[7:0]];

  irq_sequencer #(.NSRC(NSRC), .SP_INIT(SP_INIT)) u_irq_sequencer (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_done(insn_done),
    .pc_next(pc_next), .reti(reti), .gie_set(gie_set), .gie(gie), .busy(busy),
    .sp(sp), .stk_we(stk_we), .stk_wdata(stk_wdata), .stk_re(stk_re),
    .stk_rdata(stk_rdata), .pc_load(pc_load), .pc_value(pc_value)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      summary();
    end
    if (rst_n) begin
      logic [15:0] e_pcv;
      logic [7:0]  e_wd;
      int          lo;
      e_wd  = (ph == 1) ? m_ret[7:0] : (ph == 2) ? m_ret[15:8] : 8'h00;
      e_pcv = (ph == 4) ? 16'(4 * m_src) : (ph == 7) ? frames[$] : 16'h0000;
      chk("R4 busy", busy, ph != 0);
      chk("R2 gie", gie, m_gie);
      chk("R3 sp", sp, m_sp);
      chk("R3 write", {stk_we, stk_wdata}, {(ph == 1 || ph == 2), e_wd});
      chk("R8 read", stk_re, (ph == 6 || ph == 7));
      chk("R4 load", {pc_load, pc_value}, {(ph == 4 || ph == 7), e_pcv});
      if (pc_load && ph == 4) begin last_vec = pc_value; entries++; end
      if (pc_load && ph == 7) last_ret = pc_value;
      if (stk_we) mem[sp[7:0]] = stk_wdata;
      lo = 0;
      for (int i = NSRC - 1; i >= 1; i--) if (m_pend[i]) lo = i;
      case (ph)
        0: begin
          if (reti) ph = 5;
          else if (insn_done && m_gie && lo != 0) begin
            ph = 1; m_src = lo; m_ret = pc_next; frames.push_back(pc_next); m_gie = 1'b0;
          end else if (gie_set) m_gie = 1'b1;
          if (reti && gie_set) m_gie = 1'b1;
        end
        1: begin m_sp = m_sp - 1; ph = 2; if (gie_set) m_gie = 1'b1; end
        2: begin m_sp = m_sp - 1; ph = 3; if (gie_set) m_gie = 1'b1; end
        3: begin ph = 4; if (gie_set) m_gie = 1'b1; end
        4: begin ph = 0; m_pend[m_src] = 1'b0; if (gie_set) m_gie = 1'b1; end
        5: begin m_sp = m_sp + 1; ph = 6; if (gie_set) m_gie = 1'b1; end
        6: begin m_sp = m_sp + 1; ph = 7; if (gie_set) m_gie = 1'b1; end
        default: begin ph = 0; m_gie = 1'b1; void'(frames.pop_back()); end
      endcase
      m_pend = (m_pend | irq_req) & ~NSRC'(1);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise(input logic [NSRC-1:0] m);
    @(negedge clk) irq_req = m;
    @(negedge clk) irq_req = '0;
  endtask

  task automatic enable();
    @(negedge clk) gie_set = 1'b1;
    @(negedge clk) gie_set = 1'b0;
  endtask

  task automatic boundary(input logic [15:0] pc);
    @(negedge clk) begin insn_done = 1'b1; pc_next = pc; end
    @(negedge clk) insn_done = 1'b0;
    idle(6);
  endtask

  task automatic do_return();
    @(negedge clk) reti = 1'b1;
    @(negedge clk) reti = 1'b0;
    idle(5);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    idle(3);
    chk("R11 gie", gie, 1'b0);
    chk("R11 busy", busy, 1'b0);
    chk("R11 sp", sp, SP_INIT);
    @(negedge clk) rst_n = 1'b1;
    idle(2);

    // R6: request while disabled stays pending
    raise(NSRC'(1) << 3);
    boundary(16'h0100);
    chk("R6 no entry while disabled", entries, 0);
    enable();
    boundary(16'h0102);
    chk("R6 vector", last_vec, 16'h000C);
    chk("R3 low byte", mem[SP_INIT[7:0]], 8'h02);
    chk("R3 high byte", mem[SP_INIT[7:0] - 8'd1], 8'h01);
    do_return();
    chk("R8 restored", last_ret, 16'h0102);

    // R7: same source not re-entered
    boundary(16'h0104);
    chk("R7 single entry", entries, 1);

    // R9: reset slot bit ignored
    raise(NSRC'(1));
    boundary(16'h0106);
    chk("R9 bit0 ignored", entries, 1);

    // R5: lowest wins, then next
    raise((NSRC'(1) << 5) | (NSRC'(1) << 10) | (NSRC'(1) << 2));
    boundary(16'h2000);
    chk("R5 lowest", last_vec, 16'h0008);
    do_return();
    boundary(16'h2002);
    chk("R5 second", last_vec, 16'h0014);
    do_return();
    boundary(16'h2004);
    chk("R4 source 10 slot", last_vec, 16'h0028);

    // nested entry inside handler
    enable();
    raise(NSRC'(1) << (NSRC - 1));
    boundary(16'hBEEF);
    chk("R4 top source", last_vec, 16'(4 * (NSRC - 1)));
    do_return();
    chk("R8 nested inner", last_ret, 16'hBEEF);
    do_return();
    chk("R8 nested outer", last_ret, 16'h2004);

    // R10: return wins over simultaneous boundary
    raise(NSRC'(1) << 1);
    boundary(16'h3000);
    chk("R1 accept src1", last_vec, 16'h0004);
    raise(NSRC'(1) << 4);
    enable();
    @(negedge clk) begin reti = 1'b1; insn_done = 1'b1; pc_next = 16'h3100; end
    @(negedge clk) begin reti = 1'b0; insn_done = 1'b0; end
    idle(5);
    chk("R10 return first", last_ret, 16'h3000);
    chk("R10 no entry yet", last_vec, 16'h0004);
    boundary(16'h3200);
    chk("R10 pending taken later", last_vec, 16'h0010);
    do_return();
    chk("R11 sp balanced", sp, SP_INIT);
    idle(3);
    summary();
  end
endmodule